// File: doc/BRIEF.md
# Programmable Periodic Interrupt Timer

A 16-bit down-counting timer behind a small register port. Software programs a modulus, a prescale exponent and a mode, then sets the run bit; the counter steps down once per prescaled tick and, each time it expires at zero, raises a sticky hit flag and restarts from its limit. The limit is either the modulus (auto-reload mode) or 0xFFFF (free-run mode). A level interrupt follows the hit flag while the interrupt enable is set.

The register port is single-cycle. A write is taken on the rising clock edge where `bus_we` is high. Reads are combinational from `bus_addr`. Three offsets are decoded: control at 0x0000, modulus at 0x0002 and the read-only count at 0x0004. Control bit layout: bit 0 run, bit 1 auto-reload, bit 2 hit flag, bit 3 interrupt enable, bit 4 live-load, bits 5 and 6 two spare mode bits, and bits 11:8 the prescale exponent `d`. Each tick takes 2^(d+1) clock cycles.

A control write is classified before it is applied. A write that changes only the interrupt enable (apart from the flag) is a light update. Any other control write is a restart. The counting engine is a two-state machine. `ST_HALT` is left for `ST_COUNT` by a restart with run=1 (transition START). `ST_COUNT` goes back to `ST_HALT` on a restart with run=0 (transition STOP). `ST_COUNT` stays in `ST_COUNT` on a restart with run=1 (transition RELAUNCH), which reloads the count and clears the prescaler. `ST_HALT` stays in `ST_HALT` on a restart with run=0 (transition IDLE_CFG).

Top module: `pit_timer`

## Requirements
- R1: After reset, control reads 0x0000, modulus reads 0xFFFF, count reads 0x0000 and `irq` is 0.
- R2: While counting, the count decrements by one every 2^(d+1) clock cycles, where d is control bits 11:8; the first decrement comes 2^(d+1) cycles after the restart edge.
- R3: A tick taken while the count is 0 sets the hit flag (control bit 2) and, with auto-reload (bit 1) set, loads the count with the modulus.
- R4: With auto-reload clear, a restart and every expiry load the count with 0xFFFF.
- R5: `irq` is 1 exactly when the hit flag and the interrupt enable (bit 3) are both 1.
- R6: Writing control with bit 2 = 1 clears the hit flag; writing bit 2 = 0 leaves it unchanged.
- R7: Any modulus write clears the hit flag. With live-load (bit 4) set, the count takes the written value on that edge; otherwise the count is unchanged until the next reload.
- R8: A control write whose other stored bits equal the current ones, apart from bit 3 and bit 2, changes neither the count nor the tick phase.
- R9: Any other control write clears the prescaler and applies the new mode. With run (bit 0) = 1 it loads the count with the new limit. With run = 0 the count and prescaler freeze at their current values.
- R10: Writes to offset 0x0004 are ignored, and reads of undecoded offsets return 0x0000.
- R11: Bits 5 and 6 are stored and read back without affecting counting; control bits 7 and 15:12 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe, taken on the rising edge |
| bus_addr | input | 16 | Register offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| irq | output | 1 | Level interrupt |

## Verification
A wrong tick phase or a prescaler that fails to clear shows up as a count read off by one within 2^(d+1) cycles of a restart. A bad reload value or a missed expiry is visible on the count and flag reads on the very cycle after the expiry edge. A misclassified control write, either restarting when it should not or failing to restart, changes the count read on the cycle right after that write. The bench sweeps the prescale exponent 0 to 2 against two modulus values, reading the count every cycle through a full period. It then walks each write class at known tick phases.

// File: rtl/pit_pkg.sv
package pit_pkg;
    localparam logic [15:0] OFF_CTL = 16'h0000;
    localparam logic [15:0] OFF_MOD = 16'h0002;
    localparam logic [15:0] OFF_CNT = 16'h0004;

    localparam int B_GO     = 0;
    localparam int B_RELOAD = 1;
    localparam int B_HIT    = 2;
    localparam int B_HIT_IE = 3;
    localparam int B_LIVE   = 4;
    localparam int DIV_LSB  = 8;

    // stored control bits, flag kept apart
    localparam logic [15:0] CTL_KEEP = 16'h0F7B;

    typedef enum logic {
        ST_HALT,
        ST_COUNT
    } run_state_e;
endpackage

// File: rtl/pit_prescale.sv
module pit_prescale #(
    parameter int CNT_W = 16,
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    localparam int MAX_SH = CNT_W - 1;

    logic [CNT_W-1:0] pcnt;
    logic [CNT_W-1:0] top_val;

    always_comb begin
        int shamt;
        shamt   = MAX_SH - int'(div);
        top_val = {CNT_W{1'b1}} >> shamt;
    end

    assign tick = run && (pcnt == top_val);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcnt <= '0;
        end else if (restart) begin
            pcnt <= '0;
        end else if (run) begin
            pcnt <= tick ? '0 : pcnt + 1'b1;
        end
    end
endmodule

// File: rtl/pit_regs.sv
module pit_regs
    import pit_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              expire,
    output logic [DATA_W-1:0] ctl_q,
    output logic              flag_q,
    output logic [DATA_W-1:0] mod_q,
    output logic              restart,
    output logic              new_go,
    output logic              new_reload,
    output logic              load
);
    logic              ctl_sel;
    logic              mod_sel;
    logic [DATA_W-1:0] w_ctl;
    logic [DATA_W-1:0] diff;
    logic              flag_d;

    assign ctl_sel    = bus_we && (bus_addr == ADDR_W'(OFF_CTL));
    assign mod_sel    = bus_we && (bus_addr == ADDR_W'(OFF_MOD));
    assign w_ctl      = bus_wdata & DATA_W'(CTL_KEEP);
    assign diff       = (w_ctl ^ ctl_q) & ~(DATA_W'(1) << B_HIT_IE);
    assign restart    = ctl_sel && (diff != '0);
    assign new_go     = w_ctl[B_GO];
    assign new_reload = w_ctl[B_RELOAD];
    assign load       = mod_sel && ctl_q[B_LIVE];
    assign flag_d     = (flag_q && !(ctl_sel && bus_wdata[B_HIT]) && !mod_sel) || expire;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q  <= '0;
            flag_q <= 1'b0;
            mod_q  <= '1;
        end else begin
            if (ctl_sel) ctl_q <= w_ctl;
            if (mod_sel) mod_q <= bus_wdata;
            flag_q <= flag_d;
        end
    end

    assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_sel && bus_wdata[B_HIT] && !expire) |=> !flag_q);

    assert_modclr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_sel && !expire) |=> !flag_q);
endmodule

// File: rtl/pit_core.sv
module pit_core
    import pit_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         restart,
    input  logic         new_go,
    input  logic         new_reload,
    input  logic         reload,
    input  logic [W-1:0] modulus,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] count,
    output logic         running,
    output logic         expire
);
    run_state_e state, state_nx;
    logic [W-1:0] limit_now;
    logic [W-1:0] limit_new;

    assign running   = (state == ST_COUNT);
    assign limit_now = reload ? modulus : '1;
    assign limit_new = new_reload ? modulus : '1;
    assign expire    = running && tick && (count == '0) && !restart && !load;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_HALT:  if (restart && new_go)  state_nx = ST_COUNT; // START
            ST_COUNT: if (restart && !new_go) state_nx = ST_HALT;  // STOP
            default:  state_nx = ST_HALT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_HALT;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (restart) begin
            if (new_go) count <= limit_new;
        end else if (load) begin
            count <= load_val;
        end else if (running && tick) begin
            count <= (count == '0) ? limit_now : count - 1'b1;
        end
    end

    assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (running && tick && count != '0 && !restart && !load) |=> count == $past(count) - 1'b1);

    assert_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && reload) |=> count == $past(modulus));

    assert_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !restart && !load) |=> $stable(count));
endmodule

// File: rtl/pit_timer.sv
module pit_timer
    import pit_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 16,
    parameter int DIV_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    logic [DATA_W-1:0] ctl_q;
    logic [DATA_W-1:0] mod_q;
    logic [DATA_W-1:0] count;
    logic flag_q, restart, new_go, new_reload, load;
    logic tick, running, expire;

    pit_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .expire(expire),
        .ctl_q(ctl_q), .flag_q(flag_q), .mod_q(mod_q),
        .restart(restart), .new_go(new_go), .new_reload(new_reload),
        .load(load)
    );

    pit_prescale #(.CNT_W(DATA_W), .DIV_W(DIV_W)) u_pre (
        .clk(clk), .rst_n(rst_n),
        .run(running), .restart(restart),
        .div(ctl_q[DIV_LSB +: DIV_W]),
        .tick(tick)
    );

    pit_core #(.W(DATA_W)) u_core (
        .clk(clk), .rst_n(rst_n),
        .tick(tick), .restart(restart),
        .new_go(new_go), .new_reload(new_reload),
        .reload(ctl_q[B_RELOAD]), .modulus(mod_q),
        .load(load), .load_val(bus_wdata),
        .count(count), .running(running), .expire(expire)
    );

    always_comb begin
        case (bus_addr)
            ADDR_W'(OFF_CTL): bus_rdata = ctl_q | (DATA_W'(flag_q) << B_HIT);
            ADDR_W'(OFF_MOD): bus_rdata = mod_q;
            ADDR_W'(OFF_CNT): bus_rdata = count;
            default:          bus_rdata = '0;
        endcase
    end

    assign irq = ctl_q[B_HIT_IE] && flag_q;

    assert_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> flag_q);

    assert_irqdrop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(OFF_MOD) && !expire) |=> !irq);
endmodule

// File: tb/pit_timer_bench.sv
module pit_timer_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    pit_timer u_pit_timer (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    task automatic rd(input logic [15:0] a, output logic [15:0] d);
        bus_we = 1'b0;
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    // called at a negedge; commits on the next rising edge
    task automatic wr(input logic [15:0] a, input logic [15:0] d);
        bus_we = 1'b1;
        bus_addr = a;
        bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic see(input string tag, input int cnt, input int flg);
        logic [15:0] d;
        rd(16'h0004, d);
        chk({tag, " count"}, d, cnt);
        rd(16'h0000, d);
        chk({tag, " flag"}, d[2], flg);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        logic [15:0] held;
        step(3);
        rst_n = 1'b1;

        // R1 reset values
        rd(16'h0000, d); chk("R1 ctl", d, 16'h0000);
        rd(16'h0002, d); chk("R1 mod", d, 16'hFFFF);
        rd(16'h0004, d); chk("R1 cnt", d, 16'h0000);
        chk("R1 irq", irq, 0);

        // R2/R3 sweep over prescale exponent and modulus
        for (int dv = 0; dv < 3; dv++) begin
            for (int li = 0; li < 2; li++) begin
                int lim;
                int per;
                lim = (li == 0) ? 1 : 3;
                per = 2 << dv;
                wr(16'h0002, 16'(lim));
                wr(16'h0000, 16'(16'h0003 | (dv << 8)));
                for (int n = 0; n <= (lim + 1) * per; n++) begin
                    if (n < (lim + 1) * per)
                        see("R2 sweep", lim - n / per, 0);
                    else
                        see("R3 expiry reload", lim, 1);
                    if (n < (lim + 1) * per) step(1);
                end
                wr(16'h0000, 16'h0000);
            end
        end
        chk("R5 irq off with flag set", irq, 0);

        // R5/R6/R8 interrupt enable and flag handling
        wr(16'h0002, 16'd3);
        rd(16'h0000, d); chk("R7 modulus write clears flag", d[2], 0);
        wr(16'h0000, 16'h0003);
        step(10);
        see("R3 second period", 2, 1);
        wr(16'h0000, 16'h000B);
        see("R8 enable-only write", 2, 1);
        chk("R5 irq high", irq, 1);
        step(1);
        see("R8 phase kept", 1, 1);
        wr(16'h0000, 16'h000F);
        see("R6 write one clears", 1, 0);
        chk("R5 irq low after clear", irq, 0);
        step(4);
        see("R3 next expiry", 3, 1);
        chk("R5 irq again", irq, 1);
        wr(16'h0000, 16'h0003);
        see("R6 write zero keeps", 2, 1);
        chk("R5 irq off by enable", irq, 0);

        // R9 restart and stop
        wr(16'h0000, 16'h0103);
        see("R9 restart loads", 3, 1);
        step(3);
        see("R9 prescaler cleared", 3, 1);
        step(1);
        see("R9 first tick d1", 2, 1);
        wr(16'h0000, 16'h0102);
        rd(16'h0004, held);
        chk("R9 stop holds", held, 2);
        step(20);
        rd(16'h0004, d); chk("R9 frozen", d, 2);

        // R10 read-only count, undecoded offsets
        wr(16'h0004, 16'h1234);
        rd(16'h0004, d); chk("R10 count write ignored", d, 2);
        rd(16'h0006, d); chk("R10 undecoded reads 0", d, 0);
        rd(16'h0002, d); chk("R10 modulus kept", d, 3);

        // R7 deferred modulus while halted
        wr(16'h0002, 16'd7);
        see("R7 no load without live", 2, 0);

        // R11 spare bits
        wr(16'h0000, 16'hF0E0);
        rd(16'h0000, d); chk("R11 readback", d, 16'h0060);
        rd(16'h0004, d); chk("R11 halted count", d, 2);
        wr(16'h0000, 16'h0063);
        step(2);
        see("R11 counts normally", 6, 0);
        rd(16'h0000, d); chk("R11 ctl", d, 16'h0063);

        // R4/R7 free run with live load
        wr(16'h0000, 16'h0011);
        see("R4 restart to FFFF", 16'hFFFF, 0);
        wr(16'h0002, 16'd3);
        see("R7 live load", 3, 0);
        step(6);
        see("R4 at zero", 0, 0);
        step(1);
        see("R4 wrap to FFFF", 16'hFFFF, 1);

        // R7 deferred modulus while running
        wr(16'h0000, 16'h0003);
        see("R9 restart reload", 3, 1);
        step(2);
        see("R2 tick", 2, 1);
        wr(16'h0002, 16'd5);
        see("R7 count unchanged", 2, 0);
        step(5);
        see("R7 new modulus at reload", 5, 1);

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule